// File: doc/BRIEF.md
# DMA Channel Event Counter and Interrupt

This block does the event bookkeeping for one channel of a DMA engine that works through a list of commands. A separate descriptor sequencer sends it single-cycle pulses. One pulse means the command list has been loaded. Each later pulse means one command has finished. The block counts these pulses in a hardware-owned "done" count. Software keeps a "processed" count of the events it has already handled. Both counts sit in one 32-bit status word, together with an interrupt-active flag.

Software reads the status word and works out the number of new events as done minus processed, modulo 64. It acknowledges them by writing the processed field with the done value it read, and the same write clears the flag. A general configuration word sets two things. It enables the list interrupt and the command interrupt, and it chooses between a level interrupt and a one-cycle pulse per event. A channel cancel clears the counts and the flag.

Top module: `chan_evt_irq`

## Requirements
- R1: After a synchronous reset, the status word reads zero and the interrupt output is low.
- R2: A list-load pulse or a command pulse each add one to the done count on the next clock edge. Both in the same cycle add two. The count wraps from 63 to 0.
- R3: The status word holds the done count in bits [5:0], the interrupt-active flag in bit 8 and the processed count in bits [21:16]. All other bits read zero.
- R4: A write to the status word loads the processed count from bits [21:16] of the written data. The done bits of the written data have no effect on the done count.
- R5: A status write with bit 8 at zero clears the interrupt-active flag. An event pulse in the same cycle as the write still increments the done count and leaves the flag set.
- R6: Every event pulse sets the interrupt-active flag, whatever the interrupt enables are.
- R7: The configuration word has three control bits: bit 28 selects level mode, bit 29 enables the command interrupt and bit 31 enables the list interrupt. In level mode the interrupt output is high exactly when bit 29 or bit 31 is set and done differs from processed, modulo 64.
- R8: With bit 28 clear, the interrupt output pulses for one cycle after the clock edge that takes a list-load pulse while bit 31 is set, or a command pulse while bit 29 is set. At all other times it is low.
- R9: A cancel clears both counts and the flag on the next edge. It takes priority over event pulses and status writes in the same cycle, and it leaves the configuration word unchanged.
- R10: Pending events are counted modulo 64. A processed count numerically above the done count still signals events pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cancel_i | input | 1 | Channel cancel; clears the counts and the flag |
| load_evt_i | input | 1 | Pulse: a command list was loaded |
| cmd_evt_i | input | 1 | Pulse: one command completed |
| cfg_wr_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | Configuration word data |
| cnt_wr_i | input | 1 | Write strobe for the status word |
| cnt_wdata_i | input | 32 | Status word write data |
| cnt_rdata_o | output | 32 | Status word read value |
| irq_o | output | 1 | Channel interrupt |

## Verification
A done count that gains or loses a step shows in the status word one cycle after the event. It also shows as a level interrupt that stays high after a full acknowledge, or one that never rises. A lost set or clear of the flag shows in bit 8 on the cycle after the event or write. The costly cases are collisions, where an event lands in the same cycle as an acknowledge or a cancel. The bench drives those on purpose, because a wrong priority there only shows up as one missing count.

// File: rtl/chan_evt_pkg.sv
package chan_evt_pkg;
    localparam int REG_W         = 32;
    localparam int CNT_W         = 6;
    localparam int DONE_LSB      = 0;
    localparam int ACT_BIT       = 8;
    localparam int PROC_LSB      = 16;
    localparam int CFG_LEVEL_BIT = 28;
    localparam int CFG_CMD_BIT   = 29;
    localparam int CFG_LIST_BIT  = 31;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [REG_W-1:0] word_t;

    typedef struct packed {
        logic list_en;
        logic cmd_en;
        logic level_sel;
    } evt_cfg_t;

    function automatic evt_cfg_t decode_cfg(input word_t w);
        evt_cfg_t c;
        c.list_en   = w[CFG_LIST_BIT];
        c.cmd_en    = w[CFG_CMD_BIT];
        c.level_sel = w[CFG_LEVEL_BIT];
        return c;
    endfunction

    function automatic word_t pack_status(input cnt_t done, input cnt_t proc, input logic act);
        word_t w;
        w = '0;
        w[DONE_LSB +: CNT_W] = done;
        w[PROC_LSB +: CNT_W] = proc;
        w[ACT_BIT]           = act;
        return w;
    endfunction

    function automatic cnt_t pending(input cnt_t done, input cnt_t proc);
        return done - proc;
    endfunction
endpackage

// File: rtl/evt_done_ctr.sv
module evt_done_ctr #(
    parameter int CNT_W = chan_evt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cancel,
    input  logic             load_evt,
    input  logic             cmd_evt,
    output logic [CNT_W-1:0] done_o
);
    logic [CNT_W-1:0] step;

    always_comb begin
        step = CNT_W'(load_evt) + CNT_W'(cmd_evt);
    end

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            done_o <= '0;
        end else begin
            done_o <= done_o + step;
        end
    end
endmodule

// File: rtl/evt_ack_track.sv
module evt_ack_track #(
    parameter int CNT_W = chan_evt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cancel,
    input  logic             any_evt,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_proc,
    input  logic             wr_act,
    output logic [CNT_W-1:0] proc_o,
    output logic             active_o
);
    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            proc_o   <= '0;
            active_o <= 1'b0;
        end else begin
            if (wr) begin
                proc_o <= wr_proc;
            end
            if (any_evt) begin
                active_o <= 1'b1;
            end else if (wr && !wr_act) begin
                active_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen
    import chan_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cancel,
    input  logic     cfg_wr,
    input  word_t    cfg_wdata,
    input  logic     load_evt,
    input  logic     cmd_evt,
    input  logic     pend_nz,
    output evt_cfg_t cfg_o,
    output logic     irq_o
);
    logic pulse_q;
    logic level_term;
    logic unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata[30], cfg_wdata[27:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= '0;
        end else if (cfg_wr) begin
            cfg_o <= decode_cfg(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= (load_evt && cfg_o.list_en) || (cmd_evt && cfg_o.cmd_en);
        end
    end

    always_comb begin
        level_term = (cfg_o.cmd_en || cfg_o.list_en) && pend_nz;
        irq_o      = cfg_o.level_sel ? level_term : pulse_q;
    end
endmodule

// File: rtl/chan_evt_irq.sv
module chan_evt_irq
    import chan_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cancel_i,
    input  logic        load_evt_i,
    input  logic        cmd_evt_i,
    input  logic        cfg_wr_i,
    input  logic [31:0] cfg_wdata_i,
    input  logic        cnt_wr_i,
    input  logic [31:0] cnt_wdata_i,
    output logic [31:0] cnt_rdata_o,
    output logic        irq_o
);
    cnt_t     done_q;
    cnt_t     proc_q;
    logic     act_q;
    evt_cfg_t cfg_q;
    logic     pend_nz;
    logic     unused_wr_bits;

    assign unused_wr_bits = ^{cnt_wdata_i[31:PROC_LSB+CNT_W], cnt_wdata_i[PROC_LSB-1:ACT_BIT+1],
                              cnt_wdata_i[ACT_BIT-1:0]};

    evt_done_ctr #(.CNT_W(CNT_W)) u_done (
        .clk      (clk),
        .rst      (rst),
        .cancel   (cancel_i),
        .load_evt (load_evt_i),
        .cmd_evt  (cmd_evt_i),
        .done_o   (done_q)
    );

    evt_ack_track #(.CNT_W(CNT_W)) u_ack (
        .clk      (clk),
        .rst      (rst),
        .cancel   (cancel_i),
        .any_evt  (load_evt_i || cmd_evt_i),
        .wr       (cnt_wr_i),
        .wr_proc  (cnt_wdata_i[PROC_LSB +: CNT_W]),
        .wr_act   (cnt_wdata_i[ACT_BIT]),
        .proc_o   (proc_q),
        .active_o (act_q)
    );

    assign pend_nz = (pending(done_q, proc_q) != '0);

    evt_irq_gen u_irq (
        .clk       (clk),
        .rst       (rst),
        .cancel    (cancel_i),
        .cfg_wr    (cfg_wr_i),
        .cfg_wdata (cfg_wdata_i),
        .load_evt  (load_evt_i),
        .cmd_evt   (cmd_evt_i),
        .pend_nz   (pend_nz),
        .cfg_o     (cfg_q),
        .irq_o     (irq_o)
    );

    assign cnt_rdata_o = pack_status(done_q, proc_q, act_q);
endmodule

// File: rtl/chan_evt_irq_chk.sv
module chan_evt_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic        cancel_i,
    input logic        load_evt_i,
    input logic        cmd_evt_i,
    input logic        cnt_wr_i,
    input logic [31:0] cnt_rdata_o,
    input logic        irq_o,
    input logic        level_mode
);
    // R9: cancel empties the status word
    a_r9_cancel_clears: assert property (@(posedge clk) disable iff (rst)
        cancel_i |=> (cnt_rdata_o == 32'd0));

    // R2: no event keeps the done count still
    a_r2_done_hold: assert property (@(posedge clk) disable iff (rst)
        (!cancel_i && !load_evt_i && !cmd_evt_i) |=> $stable(cnt_rdata_o[5:0]));

    // R2: a single event adds one
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (!cancel_i && (load_evt_i ^ cmd_evt_i)) |=> (cnt_rdata_o[5:0] == $past(cnt_rdata_o[5:0]) + 6'd1));

    // R4: a status write alone never moves the done count
    a_r4_done_readonly: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr_i && !cancel_i && !load_evt_i && !cmd_evt_i) |=> $stable(cnt_rdata_o[5:0]));

    // R6 / R5: any event leaves the flag set
    a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
        ((load_evt_i || cmd_evt_i) && !cancel_i) |=> cnt_rdata_o[8]);

    // R7: a level interrupt implies pending events
    a_r7_level_pending: assert property (@(posedge clk) disable iff (rst)
        (level_mode && irq_o) |-> (cnt_rdata_o[5:0] != cnt_rdata_o[21:16]));

    // R3: reserved bits stay zero
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (cnt_rdata_o[31:22] == 10'd0) && (cnt_rdata_o[15:9] == 7'd0) && (cnt_rdata_o[7:6] == 2'd0));
endmodule

bind chan_evt_irq chan_evt_irq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cancel_i    (cancel_i),
    .load_evt_i  (load_evt_i),
    .cmd_evt_i   (cmd_evt_i),
    .cnt_wr_i    (cnt_wr_i),
    .cnt_rdata_o (cnt_rdata_o),
    .irq_o       (irq_o),
    .level_mode  (cfg_q.level_sel)
);

// File: tb/sim_chan_evt_irq.sv
`timescale 1ns/1ps
module sim_chan_evt_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cancel_i = 1'b0;
    logic        load_evt_i = 1'b0;
    logic        cmd_evt_i = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [31:0] cfg_wdata_i = '0;
    logic        cnt_wr_i = 1'b0;
    logic [31:0] cnt_wdata_i = '0;
    logic [31:0] cnt_rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [5:0] m_done, m_proc;
    logic m_act, m_pulse, m_lvl, m_cmden, m_listen;

    always #4 clk = ~clk;

    chan_evt_irq u0 (.*);

    function automatic logic [31:0] exp_word(input logic [5:0] d, input logic [5:0] p, input logic a);
        return {10'd0, p, 7'd0, a, 2'd0, d};
    endfunction

    function automatic logic exp_irq();
        if (m_lvl) return (m_cmden || m_listen) && (6'(m_done - m_proc) != 6'd0);
        return m_pulse;
    endfunction

    task automatic chk_word(input string tag, input logic [31:0] exp);
        checks++;
        if (cnt_rdata_o !== exp) begin
            errors++;
            $display("FAIL %s status: actual %h expected %h", tag, cnt_rdata_o, exp);
        end
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s irq: actual %b expected %b", tag, irq_o, exp);
        end
    endtask

    // one clock edge: update the model with the inputs in place, then sample at the falling edge
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_done = 0; m_proc = 0; m_act = 0; m_pulse = 0;
            m_lvl = 0; m_cmden = 0; m_listen = 0;
        end else begin
            if (cancel_i) begin
                m_done = 0; m_proc = 0; m_act = 0; m_pulse = 0;
            end else begin
                m_pulse = (load_evt_i && m_listen) || (cmd_evt_i && m_cmden);
                m_done = m_done + 6'(load_evt_i) + 6'(cmd_evt_i);
                if (cnt_wr_i) begin
                    m_proc = cnt_wdata_i[21:16];
                    if (!cnt_wdata_i[8]) m_act = 0;
                end
                if (load_evt_i || cmd_evt_i) m_act = 1;
            end
            if (cfg_wr_i) begin
                m_listen = cfg_wdata_i[31]; m_cmden = cfg_wdata_i[29]; m_lvl = cfg_wdata_i[28];
            end
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cancel_i = 0; load_evt_i = 0; cmd_evt_i = 0; cfg_wr_i = 0; cnt_wr_i = 0;
        cfg_wdata_i = '0; cnt_wdata_i = '0;
    endtask

    task automatic check_all(input string tag);
        chk_word(tag, exp_word(m_done, m_proc, m_act));
        chk_irq(tag, exp_irq());
    endtask

    task automatic set_cfg(input logic lvl, input logic cmden, input logic listen);
        idle_inputs();
        cfg_wr_i = 1;
        cfg_wdata_i = '0;
        cfg_wdata_i[28] = lvl; cfg_wdata_i[29] = cmden; cfg_wdata_i[31] = listen;
        tick();
        idle_inputs();
    endtask

    initial begin
        void'($urandom(32'd20251));
        idle_inputs();
        rst = 1;
        tick(); tick();
        rst = 0;
        check_all("R1");

        // pulse mode with both enables: load then command
        set_cfg(0, 1, 1);
        load_evt_i = 1; tick(); idle_inputs();
        check_all("R8");
        chk_word("R6", 32'h0000_0101);
        tick(); check_all("R8");
        cmd_evt_i = 1; load_evt_i = 1; tick(); idle_inputs();
        chk_word("R2", 32'h0000_0103);
        check_all("R8");

        // pulse mode with list disabled: load raises no pulse but sets flag
        set_cfg(0, 1, 0);
        load_evt_i = 1; tick(); idle_inputs();
        chk_irq("R8", 1'b0);
        chk_word("R6", exp_word(m_done, m_proc, 1'b1));

        // ack: done bits in write data ignored, flag cleared
        cnt_wr_i = 1; cnt_wdata_i = {10'd0, 6'd4, 7'd0, 1'b0, 2'd0, 6'd33}; tick(); idle_inputs();
        chk_word("R4", 32'h0004_0004);
        check_all("R5");

        // level mode: acked state low, one event high
        set_cfg(1, 1, 0);
        chk_irq("R7", 1'b0);
        cmd_evt_i = 1; tick(); idle_inputs();
        chk_irq("R7", 1'b1);
        // level mode with both enables off stays low
        set_cfg(1, 0, 0);
        chk_irq("R7", 1'b0);
        set_cfg(1, 0, 1);
        chk_irq("R7", 1'b1);

        // write collides with an event: count and flag survive
        cnt_wr_i = 1; cnt_wdata_i = {10'd0, m_done, 7'd0, 1'b0, 2'd0, 6'd0}; cmd_evt_i = 1; tick(); idle_inputs();
        check_all("R5");
        chk_word("R5", exp_word(6'd6, 6'd5, 1'b1));

        // processed numerically above done still pending
        cnt_wr_i = 1; cnt_wdata_i = {10'd0, 6'd60, 7'd0, 1'b0, 2'd0, 6'd0}; tick(); idle_inputs();
        chk_irq("R10", 1'b1);
        check_all("R10");

        // cancel with event and write the same cycle, config kept
        cancel_i = 1; cmd_evt_i = 1; cnt_wr_i = 1; cnt_wdata_i = 32'h003F_0000; tick(); idle_inputs();
        chk_word("R9", 32'd0);
        chk_irq("R9", 1'b0);
        cmd_evt_i = 1; tick(); idle_inputs();
        chk_irq("R9", 1'b1);

        // wrap of the done count
        for (int i = 0; i < 63; i++) begin
            cmd_evt_i = 1; tick();
        end
        idle_inputs();
        chk_word("R2", exp_word(6'd0, 6'd0, 1'b1));
        chk_irq("R10", 1'b0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            idle_inputs();
            load_evt_i = ($urandom % 8) == 0;
            cmd_evt_i  = ($urandom % 4) == 0;
            cancel_i   = ($urandom % 97) == 0;
            if (($urandom % 6) == 0) begin
                cnt_wr_i = 1;
                cnt_wdata_i = $urandom;
                if (($urandom % 2) == 0) cnt_wdata_i[21:16] = m_done;
            end
            if (($urandom % 40) == 0) begin
                cfg_wr_i = 1;
                cfg_wdata_i = $urandom;
            end
            tick();
            check_all("R3/R7/R8");
        end
        idle_inputs();

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule